// File: doc/BRIEF.md
# Repeated-Subtraction Integer Divider

This block divides one unsigned integer by another. It takes the quotient by counting how many times the divisor can be taken away from a running remainder. A single start pulse loads the two operands. The block then subtracts the divisor from the remainder once per clock and bumps a quotient counter each time. It stops as soon as the remainder drops below the divisor. The run time therefore grows with the quotient and is not a fixed number of cycles.

One detection unit looks at the loaded operands and decides when the loop is finished. It reports an all-zero divisor as a divide overflow, which ends the run on its first cycle with both results cleared. It also reports a remainder below the divisor, which is the normal end of the run. After either exit the block raises a done flag. The quotient, the remainder, done and the overflow flag then stay unchanged until the next accepted start. A start that arrives while a division is still running is dropped.

Top module: `divsub_top`

## Requirements
- R1: After reset, done_o and overflow_o are 0 and quotient_o and remainder_o are 0.
- R2: For a non-zero divisor, the finished result has quotient_o = floor(dividend / divisor), remainder_o = dividend mod divisor and overflow_o = 0.
- R3: For a divisor of 0, the block finishes with overflow_o = 1, quotient_o = 0 and remainder_o = 0, and done_o rises one cycle after the edge that accepts start.
- R4: Let E0 be the clock edge that accepts start. For a non-zero divisor, done_o is 0 until edge E(q+1) and is 1 after that edge, where q is the expected quotient.
- R5: A dividend smaller than a non-zero divisor gives quotient_o = 0 and remainder_o = dividend, with done_o rising after edge E1.
- R6: A start_i pulse while a division is running is ignored. The running division completes with the operands it was started with, and its latency does not change.
- R7: While done_o is 1 and start_i is 0, quotient_o, remainder_o, done_o and overflow_o hold their values, whatever is on the operand inputs.
- R8: An accepted start clears done_o and overflow_o at edge E0.
- R9: When done_o is 1 and overflow_o is 0, the remainder is smaller than the divisor that was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start command; sampled only when no division is running |
| dividend_i | input | WIDTH | Dividend; captured on an accepted start |
| divisor_i | input | WIDTH | Divisor; captured on an accepted start |
| quotient_o | output | WIDTH | Quotient counter |
| remainder_o | output | WIDTH | Running remainder, final once done_o is 1 |
| done_o | output | 1 | Result valid; stays high until the next accepted start |
| overflow_o | output | 1 | Division by zero was detected |

## Verification
Suppose the loop exit decision goes wrong, for example by stopping one subtraction early or late, or by missing a zero divisor. The port results are then off by one divisor in the remainder and by one in the quotient, and done_o shows up on the wrong edge. The bench measures the latency of every division to the exact cycle, so a fault like this shows up in the first division it affects. The bench sweeps every pair of operands in a narrow configuration. This covers the zero divisor, dividends below the divisor and the longest run (divisor 1). A control state that is wrong after an ignored start, or results that drift while idle, show up as changed outputs within the few cycles that follow.

// File: rtl/divsub_pkg.sv
// Package: shared types for the repeated-subtraction divider.
// Assumes: nothing beyond IEEE 1800-2017.
package divsub_pkg;

    // Controller state: waiting for a start, or running the subtract loop.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/divsub_exit_detect.sv
// Module: divsub_exit_detect
// Combinational loop-exit unit. It sees the registered divisor and the
// running remainder and produces three things:
//   - the difference remainder - divisor, for the next subtraction;
//   - zero_o, raised when the divisor is all zeros (divide overflow);
//   - exit_o, raised when the loop must stop (zero divisor, or a
//     remainder that has dropped below the divisor).
// Assumes: both operands are unsigned and WIDTH bits wide.
module divsub_exit_detect #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH-1:0] diff_o,
    output logic             zero_o,
    output logic             exit_o
);

    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] wide_diff;
    logic           borrow;

    // Subtract with one extra bit; the borrow out means remainder < divisor.
    always_comb begin
        wide_diff = {1'b0, rem_i} - {1'b0, dvs_i};
        borrow    = wide_diff[EXT-1];
        diff_o    = wide_diff[WIDTH-1:0];
    end

    // Zero detect on the divisor; it is also the first loop-exit reason.
    always_comb begin
        zero_o = ~|dvs_i;
        exit_o = zero_o | borrow;
    end

endmodule

// File: rtl/divsub_datapath.sv
// Module: divsub_datapath
// Holds the divisor, the running remainder and the quotient counter.
// load_i captures the operands and clears the quotient. step_i does one
// subtraction and one quotient increment. clr_i zeroes both results when
// a zero divisor is found.
// Assumes: the controller asserts at most one of load_i, step_i, clr_i in
// any cycle; the difference comes from the exit-detect unit.
module divsub_datapath #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    input  logic [WIDTH-1:0] diff_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] dvs_o,
    output logic [WIDTH-1:0] quo_o
);

    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] dvs_q;
    logic [WIDTH-1:0] quo_q;

    // Divisor register: captured on load, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)      dvs_q <= ZERO;
        else if (load_i) dvs_q <= divisor_i;
    end

    // Remainder register: load dividend, subtract per step, clear on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)      rem_q <= ZERO;
        else if (load_i) rem_q <= dividend_i;
        else if (clr_i)  rem_q <= ZERO;
        else if (step_i) rem_q <= diff_i;
    end

    // Quotient counter: cleared on load and overflow, incremented per step.
    always_ff @(posedge clk) begin
        if (!rst_n)               quo_q <= ZERO;
        else if (load_i || clr_i) quo_q <= ZERO;
        else if (step_i)          quo_q <= quo_q + ONE;
    end

    assign rem_o = rem_q;
    assign dvs_o = dvs_q;
    assign quo_o = quo_q;

    // R2: every step adds exactly one to the quotient.
    assert_quo_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !clr_i) |=> (quo_q == $past(quo_q) + ONE));

    // R2: every step takes exactly one divisor off the remainder.
    assert_rem_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !clr_i) |=> (rem_q == $past(rem_q) - $past(dvs_q)));

    // R3: an overflow exit leaves both results at zero.
    assert_clr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !load_i) |=> (rem_q == ZERO && quo_q == ZERO));

    // R7: with no command the divisor and results hold.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i && !clr_i) |=> ($stable(rem_q) && $stable(quo_q) && $stable(dvs_q)));

endmodule

// File: rtl/divsub_ctrl.sv
// Module: divsub_ctrl
// Two-state sequencer for the divider. In idle it accepts start and
// orders an operand load. In run it orders one subtraction per cycle
// until the exit-detect unit reports an exit. Then it sets done, and
// sets overflow if the exit came from a zero divisor. Start is not looked
// at during run.
// Assumes: exit_i and zero_i come straight from the exit-detect unit.
module divsub_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic exit_i,
    input  logic zero_i,
    output logic load_o,
    output logic step_o,
    output logic clr_o,
    output logic busy_o,
    output logic done_o,
    output logic ovf_o
);

    import divsub_pkg::*;

    div_state_e state_q;
    div_state_e state_d;
    logic       done_q;
    logic       ovf_q;

    // Command decode and next state for the current cycle.
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        step_o  = 1'b0;
        clr_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load_o  = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (exit_i) begin
                    clr_o   = zero_i;
                    state_d = ST_IDLE;
                end else begin
                    step_o  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Done and overflow flags: cleared by a load, set on loop exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (load_o) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (state_q == ST_RUN && exit_i) begin
            done_q <= 1'b1;
            ovf_q  <= zero_i;
        end
    end

    assign busy_o = (state_q == ST_RUN);
    assign done_o = done_q;
    assign ovf_o  = ovf_q;

    // R6: a start during a run that has not ended leaves it running, not done.
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !exit_i) |=> (busy_o && !done_o));

    // R4: loop exit is followed by done in the next cycle.
    assert_done_after_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && exit_i) |=> (done_o && !busy_o));

    // R8: an accepted start clears both flags.
    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (!done_o && !ovf_o && busy_o));

    // R3: overflow is only ever reported together with done.
    assert_ovf_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> done_o);

endmodule

// File: rtl/divsub_top.sv
// Module: divsub_top
// Repeated-subtraction unsigned divider. A start loads the operands, and
// then the divisor is taken off the remainder once per clock while the
// quotient counts up. The run ends when the remainder falls below the
// divisor, or at once on a zero divisor (overflow). Results and flags
// hold until the next accepted start.
// Assumes: synchronous active-low reset; operands are unsigned.
module divsub_top #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             done_o,
    output logic             overflow_o
);

    logic [WIDTH-1:0] rem_w;
    logic [WIDTH-1:0] dvs_w;
    logic [WIDTH-1:0] quo_w;
    logic [WIDTH-1:0] diff_w;
    logic             zero_w;
    logic             exit_w;
    logic             load_w;
    logic             step_w;
    logic             clr_w;
    logic             busy_w;

    // Exit detect: zero divisor and remainder-below-divisor.
    divsub_exit_detect #(.WIDTH(WIDTH)) u_exit (
        .rem_i  (rem_w),
        .dvs_i  (dvs_w),
        .diff_o (diff_w),
        .zero_o (zero_w),
        .exit_o (exit_w)
    );

    // Operand and result registers.
    divsub_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .step_i     (step_w),
        .clr_i      (clr_w),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .diff_i     (diff_w),
        .rem_o      (rem_w),
        .dvs_o      (dvs_w),
        .quo_o      (quo_w)
    );

    // Sequencer.
    divsub_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .exit_i  (exit_w),
        .zero_i  (zero_w),
        .load_o  (load_w),
        .step_o  (step_w),
        .clr_o   (clr_w),
        .busy_o  (busy_w),
        .done_o  (done_o),
        .ovf_o   (overflow_o)
    );

    assign quotient_o  = quo_w;
    assign remainder_o = rem_w;

    // R9: a finished, non-overflow result has remainder below divisor.
    assert_rem_below_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !overflow_o) |-> (remainder_o < dvs_w));

    // R7: with done high and no start, the outputs hold.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)
                                  && done_o && $stable(overflow_o)));

    // R3: overflow results are zero.
    assert_ovf_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (quotient_o == '0 && remainder_o == '0));

    // R6: busy and done never both high.
    assert_busy_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_w && done_o));

endmodule

// File: tb/divsub_top_tb.sv
// Bench: sweeps every operand pair in a 6-bit configuration, checking
// quotient, remainder, overflow and exact latency against arithmetic
// computed here, plus directed start-while-busy and hold cases.
module divsub_top_tb;

    localparam int W     = 6;
    localparam int NVAL  = 1 << W;
    localparam int LIMIT = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic [W-1:0] quotient_o;
    logic [W-1:0] remainder_o;
    logic         done_o;
    logic         overflow_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    divsub_top #(.WIDTH(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .done_o      (done_o),
        .overflow_o  (overflow_o)
    );

    // 125 MHz clock: 8 ns period.
    always #4 clk = ~clk;

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > LIMIT) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse start on a negedge. Return the number of edges after the
    // accepting edge E0 until done_o is seen high at a negedge.
    task automatic run_div(input int a, input int b, output int lat);
        @(negedge clk);
        start_i    = 1'b1;
        dividend_i = W'(a);
        divisor_i  = W'(b);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        chk("R8 done cleared at E0", int'(done_o), 0);
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat = lat + 1;
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 done", int'(done_o), 0);
        chk("R1 overflow", int'(overflow_o), 0);
        chk("R1 quotient", int'(quotient_o), 0);
        chk("R1 remainder", int'(remainder_o), 0);
        rst_n = 1'b1;

        // Full sweep of dividend and divisor.
        for (int b = 0; b < NVAL; b++) begin
            for (int a = 0; a < NVAL; a++) begin
                run_div(a, b, lat);
                if (b == 0) begin
                    chk("R3 overflow", int'(overflow_o), 1);
                    chk("R3 quotient", int'(quotient_o), 0);
                    chk("R3 remainder", int'(remainder_o), 0);
                    chk("R3 latency", lat, 1);
                end else begin
                    chk("R2 quotient", int'(quotient_o), a / b);
                    chk("R2 remainder", int'(remainder_o), a % b);
                    chk("R2 overflow", int'(overflow_o), 0);
                    chk("R4 latency", lat, a / b + 1);
                    chk("R9 remainder below divisor", int'(remainder_o < W'(b)), 1);
                    if (a < b) begin
                        chk("R5 quotient", int'(quotient_o), 0);
                        chk("R5 remainder", int'(remainder_o), a);
                        chk("R5 latency", lat, 1);
                    end
                end
            end
        end

        // R6: a start while running is ignored (63 / 1 runs 64 cycles).
        @(negedge clk);
        start_i    = 1'b1;
        dividend_i = W'(NVAL - 1);
        divisor_i  = W'(1);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        repeat (3) begin
            @(negedge clk);
            lat = lat + 1;
        end
        start_i    = 1'b1;
        dividend_i = W'(5);
        divisor_i  = W'(2);
        @(negedge clk);
        lat = lat + 1;
        start_i = 1'b0;
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat = lat + 1;
        end
        chk("R6 quotient", int'(quotient_o), NVAL - 1);
        chk("R6 remainder", int'(remainder_o), 0);
        chk("R6 latency", lat, NVAL);

        // R7: results hold while done and no start, operands changing.
        run_div(47, 5, lat);
        for (int k = 0; k < 6; k++) begin
            dividend_i = W'(k * 7 + 3);
            divisor_i  = W'(k);
            @(negedge clk);
            chk("R7 quotient hold", int'(quotient_o), 9);
            chk("R7 remainder hold", int'(remainder_o), 2);
            chk("R7 done hold", int'(done_o), 1);
            chk("R7 overflow hold", int'(overflow_o), 0);
        end

        // R7: an overflow result also holds.
        run_div(12, 0, lat);
        repeat (4) @(negedge clk);
        chk("R7 overflow result hold", int'(overflow_o), 1);
        chk("R7 done after overflow hold", int'(done_o), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule